// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a 32-bit-wide SDRAM from power-up to normal operation. After reset it stays silent for a fixed power-up settling time. It then issues the start-up commands on a small command interface: a precharge of all banks, a first mode-register load, eight auto-refreshes in two bursts of four, and a second mode-register load. A settling gap of about 2 µs follows each command group. The block then starts its periodic refresh timer and performs ten dummy read-then-write-back accesses to the lowest ten words. After that it raises `ready` and leaves the command bus idle.

The refresh timer divides the clock by a prescaler of 8 and counts 195 prescaled ticks. At 50 MHz that is one request every 31.2 µs, and each request stands for a burst of four refreshes. A request stays pending until the downstream scheduler acknowledges it. While a request is pending during the dummy phase, the sequencer starts no new dummy read. The memory size found later by size detection is reported on `size_mb` with a one-cycle `size_vld` strobe. If the size is 32 MB or less, the prescaler changes to 16, which halves the refresh rate. All delays are counted in clock cycles, derived from a clock-frequency parameter in MHz.

All pins are plain control and status pins. The block has no streaming interface, so no valid/ready back-pressure applies.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the outputs are `cmd`=0 (NOP), `addr`=0, `ref_req`=0 and `ready`=0. After reset is released, `cmd` stays NOP for CLK_MHZ*PWR_US cycles (10000 at the defaults). The precharge (`cmd`=1) appears in the cycle that follows, counted as that many rising edges after release.
- R2: The command codes are NOP=0, PRE=1, MRS=2, REF=3, RD=4 and WR=5, and they are issued in this order: one PRE, one MRS, four REF on consecutive cycles, four more REF on consecutive cycles, and one MRS. Exactly G=CLK_MHZ*GAP_US NOP cycles (100 at the defaults) follow each of these five groups. Exactly 31 non-NOP commands are issued before `ready` rises.
- R3: On every MRS cycle, `addr` carries the mode value 0x22 shifted left by two, which is 0x088. The mode value means CAS latency 2, burst length 4, sequential type and burst writes.
- R4: The dummy phase starts right after the gap that follows the second MRS. For each word k from 0 to 9 it issues RD and then WR on consecutive cycles, with `addr`=4*k on both cycles. When no refresh is pending, the pairs run back to back.
- R5: `ready` rises in the cycle after the last dummy WR and then stays high with `cmd` at NOP. A reset clears `ready`, and it stays low until the whole sequence has run again.
- R6: The refresh timer starts in the first cycle after the second MRS. Its first request appears DIV*195 cycles later, and requests repeat every DIV*195 cycles. DIV is 8 (1560 cycles) until a small size is reported.
- R7: Once `ref_req` is high, it stays high until a cycle with `ref_ack`=1, and it is low in the following cycle unless a new period ends in that same cycle.
- R8: A `size_vld` pulse with `size_mb`<=32 sets DIV to 16, giving a period of 3120 cycles. A pulse with `size_mb`>32 sets DIV to 8. A size of 33 therefore keeps the 1560-cycle period, and a size of 32 gives 3120.
- R9: While `ref_req` is high in the dummy phase, no RD is issued and `cmd` is NOP at every point where a read would start. A write-back always follows its read. The remaining pairs resume in the cycle after the request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_vld | input | 1 | One-cycle strobe: `size_mb` is valid |
| size_mb | input | SIZE_W | Detected memory size in megabytes |
| ref_ack | input | 1 | Scheduler has taken the pending refresh request |
| cmd | output | 3 | Command code (NOP=0, PRE=1, MRS=2, REF=3, RD=4, WR=5) |
| addr | output | ADDR_W | Mode value on MRS, byte address on dummy accesses, else 0 |
| ref_req | output | 1 | Pending request for a burst of four refreshes |
| ready | output | 1 | Initialization finished |

## Verification
A wrong delay or group counter shifts a command by at least one cycle, and the bench checks each command at its exact cycle. A miscount in the power-up wait therefore shows on the very first PRE, and a miscount in a gap shows on the next group. A wrong sequencer state shows as a missing or extra command in the 31-command total, or as `ready` rising one cycle early or late. A wrong prescaler or tick count changes the spacing between refresh requests by whole prescaler periods. A broken pending flag or hold path shows within a cycle, as a request that drops without acknowledge or a dummy read issued while a request is waiting.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_MRS = 3'd2,
    CMD_REF = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_ISSUE,
    ST_GAP,
    ST_DUMMY,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/sdram_init_ctl.sv
module sdram_init_ctl
  import sdram_init_pkg::*;
#(
  parameter int PWR_CYC   = 10000,
  parameter int GAP_CYC   = 100,
  parameter int REF_BURST = 4,
  parameter int DUMMY_N   = 10,
  parameter int ADDR_W    = 14,
  parameter int MODE_VAL  = 'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output sdram_cmd_e        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ref_en,
  output logic              ready
);

  localparam int CNT_MAX = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BC_W    = $clog2(REF_BURST + 1);
  localparam int WD_W    = $clog2(DUMMY_N + 1);
  localparam logic [2:0] G_PRE  = 3'd0;
  localparam logic [2:0] G_MRS1 = 3'd1;
  localparam logic [2:0] G_REFB = 3'd3;
  localparam logic [2:0] G_MRS2 = 3'd4;

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       grp;
  logic [BC_W-1:0]  bc;
  logic [WD_W-1:0]  wrd;
  logic             ph;
  logic             in_ref_grp;

  assign in_ref_grp = (grp != G_PRE) && (grp != G_MRS1) && (grp != G_MRS2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_WAIT;
      cnt <= CNT_W'(PWR_CYC - 1);
      grp <= G_PRE;
      bc  <= '0;
      wrd <= '0;
      ph  <= 1'b0;
    end else begin
      case (st)
        ST_WAIT: begin
          if (cnt == '0) st <= ST_ISSUE;
          else           cnt <= cnt - 1'b1;
        end
        ST_ISSUE: begin
          if (in_ref_grp && (bc != BC_W'(REF_BURST - 1))) begin
            bc <= bc + 1'b1;
          end else begin
            bc  <= '0;
            st  <= ST_GAP;
            cnt <= CNT_W'(GAP_CYC - 1);
          end
        end
        ST_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (grp == G_MRS2) begin
            st <= ST_DUMMY;
          end else begin
            grp <= grp + 1'b1;
            st  <= ST_ISSUE;
          end
        end
        ST_DUMMY: begin
          if (!ph) begin
            if (!hold) ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (wrd == WD_W'(DUMMY_N - 1)) st <= ST_DONE;
            else                           wrd <= wrd + 1'b1;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    case (st)
      ST_ISSUE: begin
        if (grp == G_PRE) begin
          cmd = CMD_PRE;
        end else if (grp == G_MRS1 || grp == G_MRS2) begin
          cmd  = CMD_MRS;
          addr = ADDR_W'(MODE_VAL << 2);
        end else begin
          cmd = CMD_REF;
        end
      end
      ST_DUMMY: begin
        addr = ADDR_W'({wrd, 2'b00});
        if (ph)         cmd = CMD_WR;
        else if (!hold) cmd = CMD_RD;
      end
      default: ;
    endcase
  end

  assign ref_en = ((st == ST_GAP) && (grp == G_MRS2)) || (st == ST_DUMMY) || (st == ST_DONE);
  assign ready  = (st == ST_DONE);

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 16,
  parameter int TICKS    = 195,
  parameter int SIZE_W   = 10,
  parameter int SMALL_MB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              size_vld,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              ack,
  output logic              req
);

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PRE_W   = $clog2(DIV_MAX + 1);
  localparam int PER_W   = $clog2(TICKS + 1);

  logic             slow;
  logic [PRE_W-1:0] pre;
  logic [PER_W-1:0] per;
  logic [PRE_W-1:0] pre_last;
  logic             tick;
  logic             period_end;

  assign pre_last   = slow ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
  assign tick       = en && (pre >= pre_last);
  assign period_end = tick && (per == PER_W'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow <= 1'b0;
    end else if (size_vld) begin
      slow <= (size_mb <= SIZE_W'(SMALL_MB));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      per <= '0;
    end else if (!en) begin
      pre <= '0;
      per <= '0;
    end else if (tick) begin
      pre <= '0;
      per <= period_end ? '0 : per + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= period_end | (req & ~ack);
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int PWR_US    = 200,
  parameter int GAP_US    = 2,
  parameter int REF_TICKS = 195,
  parameter int DIV_FAST  = 8,
  parameter int DIV_SLOW  = 16,
  parameter int REF_BURST = 4,
  parameter int DUMMY_N   = 10,
  parameter int ADDR_W    = 14,
  parameter int SIZE_W    = 10,
  parameter int SMALL_MB  = 32,
  parameter int MODE_VAL  = 'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_vld,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              ref_ack,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ref_req,
  output logic              ready
);

  localparam int PWR_CYC = CLK_MHZ * PWR_US;
  localparam int GAP_CYC = CLK_MHZ * GAP_US;

  sdram_cmd_e cmd_e;
  logic       ref_en;

  sdram_init_ctl #(
    .PWR_CYC  (PWR_CYC),
    .GAP_CYC  (GAP_CYC),
    .REF_BURST(REF_BURST),
    .DUMMY_N  (DUMMY_N),
    .ADDR_W   (ADDR_W),
    .MODE_VAL (MODE_VAL)
  ) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (ref_req),
    .cmd   (cmd_e),
    .addr  (addr),
    .ref_en(ref_en),
    .ready (ready)
  );

  sdram_ref_timer #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW),
    .TICKS   (REF_TICKS),
    .SIZE_W  (SIZE_W),
    .SMALL_MB(SMALL_MB)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ref_en),
    .size_vld(size_vld),
    .size_mb (size_mb),
    .ack     (ref_ack),
    .req     (ref_req)
  );

  assign cmd = cmd_e;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W   = 14,
  parameter int MODE_VAL = 'h22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              ready
);

  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  // R9
  no_read_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (cmd != 3'd4));

  // R4
  writeback_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |=> ((cmd == 3'd5) && $stable(addr)));

  // R3
  mrs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> (addr == ADDR_W'(MODE_VAL << 2)));

  // R5
  ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == 3'd0));

  // R5
  ready_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cmd) == 3'd5));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W  (ADDR_W),
  .MODE_VAL(MODE_VAL)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cmd    (cmd),
  .addr   (addr),
  .ref_req(ref_req),
  .ref_ack(ref_ack),
  .ready  (ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int P  = 10000;
  localparam int G  = 100;
  localparam int D  = P + 11 + 5 * G;
  localparam int M  = P + 11 + 4 * G;
  localparam int FIRST_REF = M + 8 * 195;
  localparam int NV = 14;

  // cycle, expected cmd, expected addr, requirement number
  localparam int TC [NV] = '{P-1, P, P+1, P+1+G, P+2+2*G, P+5+2*G, P+6+2*G,
                             P+6+3*G, P+9+3*G, P+10+4*G, D, D+1, D+18, D+19};
  localparam int TK [NV] = '{0, 1, 0, 2, 3, 3, 0, 3, 3, 2, 4, 5, 4, 5};
  localparam int TA [NV] = '{0, 0, 0, 'h88, 0, 0, 0, 0, 0, 'h88, 0, 0, 36, 36};
  localparam int TR [NV] = '{1, 1, 2, 3, 2, 2, 2, 2, 2, 3, 4, 4, 4, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst2_n = 1'b0;
  logic        size_vld = 1'b0;
  logic [9:0]  size_mb = '0;
  logic        ref_ack = 1'b0;
  logic        ref_ack2 = 1'b0;
  logic [2:0]  cmd, cmd2;
  logic [13:0] addr, addr2;
  logic        ref_req, ref_req2, ready, ready2;

  int cyc = 0;
  int cyc2 = 0;
  int nn = 0;
  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  sdram_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .size_vld(size_vld), .size_mb(size_mb),
    .ref_ack(ref_ack), .cmd(cmd), .addr(addr), .ref_req(ref_req), .ready(ready)
  );

  sdram_init_seq #(.CLK_MHZ(1), .REF_TICKS(2)) u_dut2 (
    .clk(clk), .rst_n(rst2_n), .size_vld(1'b0), .size_mb(10'd0),
    .ref_ack(ref_ack2), .cmd(cmd2), .addr(addr2), .ref_req(ref_req2), .ready(ready2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (!rst2_n) cyc2 <= 0; else cyc2 <= cyc2 + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) nn = 0;
    else if (!ready && cmd != 3'd0) nn = nn + 1;
    ref_ack <= ref_req && !ref_ack;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic wait_cyc2(input int n);
    while (cyc2 != n) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    logic pv;
    pv = ref_req;
    @(negedge clk);
    while (!(ref_req && !pv)) begin
      pv = ref_req;
      @(negedge clk);
    end
    t = cyc;
  endtask

  task automatic give_size(input int mb);
    size_mb  = 10'(mb);
    size_vld = 1'b1;
    @(negedge clk);
    size_vld = 1'b0;
  endtask

  initial begin
    #1_500_000;
    nbad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int ta, tb, tc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd == 3'd0, "R1 reset cmd", cmd, 0);
    chk(addr == 14'd0, "R1 reset addr", addr, 0);
    chk(ref_req == 1'b0, "R1 reset ref_req", ref_req, 0);
    chk(ready == 1'b0, "R1 reset ready", ready, 0);

    // short-timing instance: refresh priority in dummy phase
    rst2_n = 1'b1;
    wait_cyc2(234);
    chk(ref_req2 == 1'b0, "R6 dut2 no req before period", ref_req2, 0);
    chk(cmd2 == 3'd5 && addr2 == 14'd24, "R4 dut2 WR word6", cmd2, 5);
    wait_cyc2(235);
    chk(ref_req2 == 1'b1, "R6 dut2 first req", ref_req2, 1);
    chk(cmd2 == 3'd0, "R9 dut2 read held", cmd2, 0);
    wait_cyc2(236);
    chk(cmd2 == 3'd0 && ready2 == 1'b0, "R9 dut2 still yielding", cmd2, 0);
    wait_cyc2(240);
    chk(ref_req2 == 1'b1, "R7 req held without ack", ref_req2, 1);
    ref_ack2 = 1'b1;
    @(negedge clk);
    ref_ack2 = 1'b0;
    chk(ref_req2 == 1'b0, "R7 req cleared after ack", ref_req2, 0);
    chk(cmd2 == 3'd4 && addr2 == 14'd28, "R9 dut2 resumes RD word7", cmd2, 4);
    wait_cyc2(246);
    chk(cmd2 == 3'd5 && addr2 == 14'd36, "R9 dut2 last WR", cmd2, 5);
    chk(ready2 == 1'b0, "R5 dut2 not ready at last WR", ready2, 0);
    wait_cyc2(247);
    chk(ready2 == 1'b1, "R5 dut2 ready after stall", ready2, 1);

    // main instance: command schedule table (R1 R2 R3 R4)
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wait_cyc(TC[i]);
      chk(cmd == 3'(TK[i]), $sformatf("R%0d cmd at cycle %0d", TR[i], TC[i]), cmd, TK[i]);
      chk(addr == 14'(TA[i]), $sformatf("R%0d addr at cycle %0d", TR[i], TC[i]), addr, TA[i]);
    end
    chk(ready == 1'b0, "R5 not ready at last WR", ready, 0);
    wait_cyc(D + 20);
    chk(ready == 1'b1, "R5 ready after dummies", ready, 1);
    wait_cyc(D + 21);
    chk(nn == 31, "R2 non-NOP command count", nn, 31);
    chk(cmd == 3'd0, "R5 idle after ready", cmd, 0);

    // R6: refresh timer start and fast period
    wait_rise(ta);
    chk(ta == FIRST_REF, "R6 first refresh cycle", ta, FIRST_REF);
    give_size(64);
    wait_rise(ta);
    wait_rise(tb);
    chk(tb - ta == 1560, "R8 period for 64MB", tb - ta, 1560);
    // R8: boundary just above small
    give_size(33);
    wait_rise(ta);
    wait_rise(tb);
    chk(tb - ta == 1560, "R8 period for 33MB", tb - ta, 1560);
    // R8: boundary at small limit
    give_size(32);
    wait_rise(ta);
    wait_rise(tb);
    wait_rise(tc);
    chk(tc - tb == 3120, "R8 period for 32MB", tc - tb, 3120);

    // R5: reset in operation clears ready, sequence restarts
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R5 ready cleared by reset", ready, 0);
    chk(ref_req == 1'b0 && cmd == 3'd0, "R1 outputs in second reset", cmd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(P - 1);
    chk(cmd == 3'd0 && ready == 1'b0, "R1 silent before PRE after reset", cmd, 0);
    wait_cyc(P);
    chk(cmd == 3'd1, "R1 PRE after second reset", cmd, 1);
    chk(ready == 1'b0, "R5 ready low during rerun", ready, 0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule